// File: doc/BRIEF.md
# Bandwidth Reservation Limit Checker

This block keeps the reserved-bandwidth budget for a memory-bandwidth quality-of-service controller. Bandwidth is handed out in whole blocks. For every resource-control ID and each of two access types (code and data) the block holds a count of reserved blocks. Software places a block count in a staging register and then issues a command naming an operation, a control ID and an access type.

A configure command checks the staged count against a per-request range and a global budget, and commits it only if both checks pass. The global budget is a running total of every reservation across all control IDs and both access types. When a reservation is replaced, the old value for the same control ID and access type is taken out of the total before the new one is added. A read command copies a stored count back into the staging register. Each command occupies the block for one busy cycle, and its result status is ready when busy falls.

Top module: `bw_limit_top`

## Requirements
- R1: After reset, status is 0 (idle), busy is 0, the staging register reads 0 and every stored count is 0.
- R2: A command is accepted on a clock edge where cmdValid is 1 and busy is 0. Busy is then 1 for exactly one cycle, and the result status appears on the edge where busy returns to 0. A cmdValid seen while busy is 1 is ignored.
- R3: A configure command (cmdOp = 1) whose staged count lies in 1..MAX_RES, and whose new total fits, stores the count for the addressed ID and access type and reports status 1 (success).
- R4: A configure command with a staged count of 0, or a count above MAX_RES, reports status 2 (invalid operation) and changes no stored count.
- R5: A configure command is refused with status 4 (no room) when the total of all stored counts, minus the old count of the addressed entry, plus the staged count, exceeds MAX_RES. A total equal to MAX_RES is accepted. A refused command leaves every count unchanged.
- R6: A control ID at or above NUM_RCID reports status 3 (invalid ID) for any operation. This check comes before all others, and the command changes no count and does not touch the staging register.
- R7: A read command (cmdOp = 2) copies the stored count of the addressed entry into the staging register, reports status 1, and changes no stored count.
- R8: Counts for access type 0 (code) and access type 1 (data) of the same ID are stored separately.
- R9: An operation code of 0 or 3 reports status 2 and has no other effect.
- R10: A staging write (stageWrEn) loads stageWrData when busy is 0 and is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Operation: 1 configure, 2 read, others invalid |
| cmdRcid | input | RCID_W | Resource-control ID |
| cmdAt | input | AT_W | Access type: 0 code, 1 data |
| stageWrEn | input | 1 | Write strobe for the staging register |
| stageWrData | input | CNT_W | Block count to stage |
| stageData | output | CNT_W | Staging register contents |
| busy | output | 1 | A command is executing |
| status | output | 3 | Result: 0 idle, 1 success, 2 invalid operation, 3 invalid ID, 4 no room |

## Verification
The assertions assume the block leaves reset with a zero total. They also assume that at most one staging update is in progress at a time, which the busy gating of staging writes provides. Under these conditions the total can never rise above MAX_RES, and it can change only on a commit. The stimulus issues one command at a time, drives its inputs on the falling edge, and waits for busy to fall before it starts the next command. On purpose, it also attempts staging writes and a second command during the busy cycle. Counts are chosen to land exactly on the budget, one block over it, and on the replace-and-shrink case, where the old value must be taken out of the total.

// File: rtl/bw_limit_pkg.sv
package bw_limit_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_GET  = 2'd2,
    OP_RSVD = 2'd3
  } cmdOp_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_OK      = 3'd1,
    ST_BAD_OP  = 3'd2,
    ST_BAD_ID  = 3'd3,
    ST_NO_ROOM = 3'd4
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch ID and access type of an accepted command
    logic stageWr;   // load staging register from the port
    logic commit;    // store staged count and update running total
    logic readBack;  // copy stored count into staging register
  } dpStrobe_t;

  // check results from datapath to control
  typedef struct packed {
    logic belowMin;
    logic aboveMax;
    logic overSum;
  } dpFlags_t;

endpackage

// File: rtl/bw_limit_dp.sv
module bw_limit_dp
  import bw_limit_pkg::*;
#(
  parameter int NUM_RCID = 12,
  parameter int NUM_AT   = 2,
  parameter int CNT_W    = 8,
  parameter int MAX_RES  = 40,
  parameter int RCID_W   = 4,
  parameter int AT_W     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [RCID_W-1:0] cmdRcid,
  input  logic [AT_W-1:0]   cmdAt,
  input  logic [CNT_W-1:0]  stageWrData,
  output logic [CNT_W-1:0]  stageData,
  output dpFlags_t          flags
);

  localparam int NUM_ENT = NUM_RCID * NUM_AT;
  localparam int SUM_W   = $clog2(MAX_RES + 1);
  localparam int CALC_W  = ((SUM_W > CNT_W) ? SUM_W : CNT_W) + 1;

  logic [RCID_W-1:0] rcidQ;
  logic [AT_W-1:0]   atQ;
  logic [CNT_W-1:0]  stageQ;
  logic [SUM_W-1:0]  sumQ;
  logic [CNT_W-1:0]  limitArr [NUM_RCID][NUM_AT];
  logic [NUM_ENT-1:0] weVec;
  logic [CNT_W-1:0]  oldVal;
  logic [CALC_W-1:0] candSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcidQ <= '0;
      atQ   <= '0;
    end else if (strobe.capture) begin
      rcidQ <= cmdRcid;
      atQ   <= cmdAt;
    end
  end

  // per-entry write enables
  for (genvar r = 0; r < NUM_RCID; r++) begin : g_id
    for (genvar a = 0; a < NUM_AT; a++) begin : g_at
      assign weVec[r*NUM_AT + a] = strobe.commit &&
                                   (rcidQ == RCID_W'(r)) && (atQ == AT_W'(a));
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_RCID; r++) begin
      for (int a = 0; a < NUM_AT; a++) begin
        if (!rstN)
          limitArr[r][a] <= '0;
        else if (weVec[r*NUM_AT + a])
          limitArr[r][a] <= stageQ;
      end
    end
  end

  // lookup of the addressed entry; an unimplemented ID reads as zero
  always_comb begin
    oldVal = '0;
    for (int r = 0; r < NUM_RCID; r++) begin
      for (int a = 0; a < NUM_AT; a++) begin
        if ((rcidQ == RCID_W'(r)) && (atQ == AT_W'(a)))
          oldVal = limitArr[r][a];
      end
    end
  end

  assign candSum = CALC_W'(sumQ) - CALC_W'(oldVal) + CALC_W'(stageQ);

  assign flags.belowMin = (stageQ == '0);
  assign flags.aboveMax = (CALC_W'(stageQ) > CALC_W'(MAX_RES));
  assign flags.overSum  = (candSum > CALC_W'(MAX_RES));

  always_ff @(posedge clk) begin
    if (!rstN)
      sumQ <= '0;
    else if (strobe.commit)
      sumQ <= SUM_W'(candSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      stageQ <= '0;
    else if (strobe.stageWr)
      stageQ <= stageWrData;
    else if (strobe.readBack)
      stageQ <= oldVal;
  end

  assign stageData = stageQ;

  // running total never leaves the budget (R5)
  p_sum_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    sumQ <= SUM_W'(MAX_RES));

  // total moves only on a commit (R4)
  p_sum_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(sumQ));

  // staging register moves only on a port write or read-back (R10)
  p_stage_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stageWr && !strobe.readBack) |=> $stable(stageQ));

endmodule

// File: rtl/bw_limit_ctrl.sv
module bw_limit_ctrl
  import bw_limit_pkg::*;
#(
  parameter int NUM_RCID = 12,
  parameter int RCID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [RCID_W-1:0] cmdRcid,
  input  logic              stageWrEn,
  input  dpFlags_t          flags,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic [2:0]        status
);

  typedef enum logic {S_IDLE, S_EXEC} state_e;

  state_e  state;
  cmdOp_e  opQ;
  logic    idOkQ;
  status_e statusQ;
  status_e nextStatus;
  logic    accept;
  logic    doCommit;
  logic    doRead;

  assign accept = cmdValid && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_NONE;
      idOkQ <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_EXEC;
          opQ   <= cmdOp_e'(cmdOp);
          idOkQ <= ({1'b0, cmdRcid} < (RCID_W+1)'(NUM_RCID));
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // decision: ID first, then operation, then range, then budget
  always_comb begin
    nextStatus = statusQ;
    doCommit   = 1'b0;
    doRead     = 1'b0;
    if (state == S_EXEC) begin
      if (!idOkQ) begin
        nextStatus = ST_BAD_ID;
      end else begin
        case (opQ)
          OP_SET: begin
            if (flags.belowMin || flags.aboveMax)
              nextStatus = ST_BAD_OP;
            else if (flags.overSum)
              nextStatus = ST_NO_ROOM;
            else begin
              nextStatus = ST_OK;
              doCommit   = 1'b1;
            end
          end
          OP_GET: begin
            nextStatus = ST_OK;
            doRead     = 1'b1;
          end
          default: nextStatus = ST_BAD_OP;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= ST_IDLE;
    else       statusQ <= nextStatus;
  end

  assign strobe.capture  = accept;
  assign strobe.stageWr  = stageWrEn && (state == S_IDLE);
  assign strobe.commit   = doCommit;
  assign strobe.readBack = doRead;
  assign busy            = (state == S_EXEC);
  assign status          = statusQ;

  // busy lasts one cycle (R2)
  p_one_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // a finished command always leaves a non-idle result (R2)
  p_status_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (status != 3'd0));

  // commits only with a count inside the range (R4)
  p_commit_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (!flags.belowMin && !flags.aboveMax));

  // commits only when the budget allows (R5)
  p_commit_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> !flags.overSum);

  // commit and read-back never coincide (R7)
  p_one_action_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commit, strobe.readBack, strobe.stageWr}));

endmodule

// File: rtl/bw_limit_top.sv
module bw_limit_top
  import bw_limit_pkg::*;
#(
  parameter int NUM_RCID = 12,
  parameter int NUM_AT   = 2,
  parameter int CNT_W    = 8,
  parameter int MAX_RES  = 40,
  parameter int RCID_W   = 4,
  parameter int AT_W     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [RCID_W-1:0] cmdRcid,
  input  logic [AT_W-1:0]   cmdAt,
  input  logic              stageWrEn,
  input  logic [CNT_W-1:0]  stageWrData,
  output logic [CNT_W-1:0]  stageData,
  output logic              busy,
  output logic [2:0]        status
);

  dpStrobe_t strobe;
  dpFlags_t  flags;

  bw_limit_ctrl #(
    .NUM_RCID (NUM_RCID),
    .RCID_W   (RCID_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdRcid   (cmdRcid),
    .stageWrEn (stageWrEn),
    .flags     (flags),
    .strobe    (strobe),
    .busy      (busy),
    .status    (status)
  );

  bw_limit_dp #(
    .NUM_RCID (NUM_RCID),
    .NUM_AT   (NUM_AT),
    .CNT_W    (CNT_W),
    .MAX_RES  (MAX_RES),
    .RCID_W   (RCID_W),
    .AT_W     (AT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdRcid     (cmdRcid),
    .cmdAt       (cmdAt),
    .stageWrData (stageWrData),
    .stageData   (stageData),
    .flags       (flags)
  );

endmodule

// File: tb/bw_limit_top_test.sv
module bw_limit_top_test;

  localparam int NUM_RCID = 12;
  localparam int CNT_W    = 8;
  localparam int MAX_RES  = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [3:0] cmdRcid = 4'd0;
  logic [0:0] cmdAt = 1'b0;
  logic       stageWrEn = 1'b0;
  logic [7:0] stageWrData = 8'd0;
  logic [7:0] stageData;
  logic       busy;
  logic [2:0] status;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model
  int modelLim [NUM_RCID][2];
  int modelStage = 0;

  logic [2:0] expStatusQ [$];
  logic [7:0] expStageQ  [$];
  string      expTagQ    [$];

  always #4 clk = ~clk;  // 125 MHz

  bw_limit_top uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdRcid(cmdRcid), .cmdAt(cmdAt), .stageWrEn(stageWrEn),
    .stageWrData(stageWrData), .stageData(stageData), .busy(busy),
    .status(status)
  );

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modelSum();
    int s = 0;
    for (int r = 0; r < NUM_RCID; r++)
      for (int a = 0; a < 2; a++) s += modelLim[r][a];
    return s;
  endfunction

  // predicts the result from the requirements and pushes it
  task automatic predict(int op, int rcid, int at, string tag);
    int st;
    if (rcid >= NUM_RCID) st = 3;                       // R6
    else if (op == 1) begin
      if (modelStage < 1 || modelStage > MAX_RES) st = 2; // R4
      else if (modelSum() - modelLim[rcid][at] + modelStage > MAX_RES) st = 4; // R5
      else begin st = 1; modelLim[rcid][at] = modelStage; end // R3
    end else if (op == 2) begin
      st = 1; modelStage = modelLim[rcid][at];           // R7
    end else st = 2;                                    // R9
    expStatusQ.push_back(3'(st));
    expStageQ.push_back(8'(modelStage));
    expTagQ.push_back(tag);
  endtask

  // one command; optional staged value, junk staging write and a second
  // command attempt during the busy cycle
  task automatic issue(int op, int rcid, int at, bit doStage, int stVal,
                       bit junk, bit hold, string tag);
    @(negedge clk);
    if (doStage) begin
      stageWrEn   = 1'b1;
      stageWrData = 8'(stVal);
      modelStage  = stVal;
    end
    cmdValid = 1'b1;
    cmdOp    = 2'(op);
    cmdRcid  = 4'(rcid);
    cmdAt    = 1'(at);
    predict(op, rcid, at, tag);
    @(negedge clk);
    stageWrEn   = junk;
    stageWrData = 8'hAA;
    cmdValid    = hold;
    cmdOp       = 2'd1;
    cmdRcid     = 4'd7;
    @(negedge clk);
    stageWrEn = 1'b0;
    cmdValid  = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare on the falling of busy
  initial begin
    logic prevBusy = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && prevBusy && !busy) begin
        if (expStatusQ.size() == 0) begin
          check("R2 unexpected result", 1, 0);
        end else begin
          string t = expTagQ.pop_front();
          check({t, " status"}, int'(status), int'(expStatusQ.pop_front()));
          check({t, " stage"}, int'(stageData), int'(expStageQ.pop_front()));
        end
      end
      prevBusy = busy;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NUM_RCID; r++) begin
      modelLim[r][0] = 0;
      modelLim[r][1] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", int'(status), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 stage", int'(stageData), 0);

    issue(2, 3, 0, 0, 0, 0, 0, "R1 read after reset");
    issue(1, 0, 0, 1, 10, 0, 0, "R3 set id0 code");
    issue(1, 1, 1, 1, 15, 0, 0, "R3 set id1 data");
    issue(1, 2, 0, 1, 0, 0, 0, "R4 zero count");
    issue(1, 2, 0, 1, 41, 0, 0, "R4 above max");
    issue(1, 2, 0, 1, 200, 0, 0, "R4 far above max");
    issue(1, 2, 0, 1, 16, 0, 0, "R5 one over budget");
    issue(1, 2, 0, 1, 15, 0, 0, "R5 exactly at budget");
    issue(1, 0, 0, 1, 25, 0, 0, "R5 replace over budget");
    issue(1, 0, 0, 1, 10, 0, 0, "R5 replace same value");
    issue(1, 0, 0, 1, 5, 0, 0, "R5 replace shrink");
    issue(1, 12, 0, 1, 1, 0, 0, "R6 set bad id");
    issue(2, 15, 1, 0, 0, 0, 0, "R6 read bad id");
    issue(0, 1, 0, 0, 0, 0, 0, "R9 op zero");
    issue(3, 1, 0, 0, 0, 0, 0, "R9 op three");
    issue(2, 0, 0, 0, 0, 0, 0, "R7 read id0 code");
    issue(2, 0, 1, 0, 0, 0, 0, "R8 read id0 data");
    issue(2, 1, 1, 0, 0, 0, 0, "R8 read id1 data");
    issue(2, 1, 0, 0, 0, 0, 0, "R8 read id1 code");
    issue(1, 5, 1, 1, 3, 1, 0, "R10 junk stage write while busy");
    issue(2, 6, 0, 0, 0, 0, 1, "R2 command while busy ignored");
    issue(2, 7, 1, 0, 0, 0, 0, "R2 second command had no effect");
    issue(2, 2, 0, 0, 0, 0, 0, "R7 read id2 code");
    issue(2, 5, 1, 0, 0, 0, 0, "R7 read id5 data");

    repeat (4) @(negedge clk);
    check("R2 all results seen", expStatusQ.size(), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule